// File: doc/BRIEF.md
# Keyed Configuration Port Unlocker

This block is the configuration front end of a multi-function I/O controller. It watches byte writes on a simple host I/O bus. Two addresses matter: an index port and a data port. After reset the port is locked. Data-port writes do nothing while locked, and data-port reads return 0xFF. Meanwhile a small matcher follows the bytes written to the index port and waits for a fixed four-byte unlock key.

Once the port is unlocked, a write to the index port chooses a configuration register, and data-port accesses reach that register. Index 0x07 holds the logical-device number. Indices from 0x30 upward are banked: the block hands each such access to the selected logical device through a register-access port (bank, index, write data, write strobe, read data). The chip identity and revision are fixed by parameters and can only be read. Writing 0x02 to the data port while the index is 0x02 locks the port again.

Top module: `cfg_keyport`

## Requirements
- R1: After reset the port is locked, `io_rdata` is 0xFF, `ld_we` is 0, and `ld_bank` and `ld_index` are 0x00.
- R2: The port unlocks after four consecutive writes to the index port (address 0x002E) carrying 0x87, 0x01, 0x55 and 0x55, in that order. While the port is locked, index-port writes do not change the selected index.
- R3: A byte that breaks the key sends the matcher back to its start. If that byte is 0x87, it counts as the first byte of a new key, so 0x87 0x01 0x87 0x01 0x55 0x55 unlocks and so does 0x87 0x87 0x01 0x55 0x55.
- R4: While the port is locked, writes to the data port (address 0x002F) are ignored: no `ld_we` pulse and no register change. Data-port reads return 0xFF.
- R5: While the port is unlocked, index 0x07 is the logical-device number. It can be both read and written, and `ld_bank` always shows its current value.
- R6: Index 0x20 reads the high byte of the chip ID and index 0x21 reads the low byte. Writes to either index are ignored.
- R7: Index 0x22 reads the revision. Only its low nibble is returned, and the upper four bits read as 0.
- R8: While the port is unlocked with an index of 0x30 or above, a data write raises `ld_we` for one cycle, one edge after the write. During that pulse `ld_wdata` holds the written byte, `ld_index` holds the index and `ld_bank` holds the device number. A data read returns `ld_rdata`.
- R9: A data write of 0x02 while the index is 0x02 locks the port again. A data write of any other value at index 0x02 leaves the port unlocked.
- R10: Indices below 0x30 that have no register assigned read 0x00. Data writes to them produce no `ld_we` pulse.
- R11: Accesses to any address other than the two ports have no effect.
- R12: Read data is registered on the clock edge at which `io_rd` is sampled high at the data port. It then holds until the next data-port read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one byte per cycle |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Registered read byte for the data port |
| ld_bank | output | 8 | Selected logical-device number |
| ld_index | output | 8 | Selected configuration index |
| ld_wdata | output | 8 | Byte for a banked register write |
| ld_we | output | 1 | One-cycle banked write strobe |
| ld_rdata | input | 8 | Banked register read byte from the selected device |

## Verification
Every result becomes visible one clock edge after the strobe that causes it. A data read appears on `io_rdata`, a banked write appears as the `ld_we` pulse with its data, and a key byte or exit command changes the lock state. Lock state has no output of its own, so it is observed through the data read that follows. The bench drives each strobe at a falling edge and releases it at the next falling edge. It checks the result at that second falling edge, after the capturing rising edge has passed. The read scoreboard compares only at falling edges that follow a captured read, so every expected byte is matched to exactly one read.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned KEY_MAX_BYTES = 8;
  localparam logic [7:0] LDN_IDX   = 8'h07;
  localparam logic [7:0] ID_HI_IDX = 8'h20;
  localparam logic [7:0] ID_LO_IDX = 8'h21;
  localparam logic [7:0] REV_IDX   = 8'h22;
  localparam logic [7:0] EXIT_IDX  = 8'h02;
  localparam logic [7:0] EXIT_CMD  = 8'h02;
  localparam logic [7:0] BANK_BASE = 8'h30;
  localparam logic [7:0] IDLE_READ = 8'hFF;

  // Byte i of a key packed first-byte-most-significant, len bytes long.
  function automatic logic [7:0] key_byte(input logic [8*KEY_MAX_BYTES-1:0] key,
                                          input int unsigned len,
                                          input int unsigned i);
    return key[8*(len-1-i) +: 8];
  endfunction

  function automatic logic is_bank_idx(input logic [7:0] idx);
    return idx >= BANK_BASE;
  endfunction

  // Value of an unbanked register.
  function automatic logic [7:0] global_value(input logic [7:0] idx,
                                              input logic [7:0] ldn,
                                              input logic [15:0] chip_id,
                                              input logic [7:0] chip_rev);
    case (idx)
      LDN_IDX:   return ldn;
      ID_HI_IDX: return chip_id[15:8];
      ID_LO_IDX: return chip_id[7:0];
      REV_IDX:   return {4'h0, chip_rev[3:0]};
      default:   return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgp_key_match.sv
module cfgp_key_match
  import cfgp_pkg::*;
#(
  parameter int unsigned KEY_LEN = 4,
  parameter logic [8*KEY_MAX_BYTES-1:0] KEY = 64'h0000_0000_8701_5555
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       unlock_evt
);
  localparam int unsigned STEP_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [7:0] FIRST_BYTE = key_byte(KEY, KEY_LEN, 0);

  logic [STEP_W-1:0] step;
  logic              key_hit;
  logic              key_last;
  logic              key_restart;

  assign key_hit     = key_data == key_byte(KEY, KEY_LEN, int'(step));
  assign key_last    = int'(step) == KEY_LEN - 1;
  assign key_restart = !key_hit && key_data == FIRST_BYTE;
  assign unlock_evt  = key_wr && key_hit && key_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
    end else if (key_wr) begin
      if (key_hit && !key_last) step <= step + 1'b1;
      else if (key_restart)     step <= STEP_W'(1);
      else                      step <= '0;
    end
  end
endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  input  logic       unlock_evt,
  output logic       unlocked,
  output logic       exit_evt,
  output logic [7:0] cur_index,
  output logic [7:0] ldn,
  output logic       ld_we,
  output logic [7:0] ld_wdata
);
  logic bank_wr;
  logic ldn_wr;

  assign exit_evt = unlocked && dat_wr && cur_index == EXIT_IDX && wdata == EXIT_CMD;
  assign bank_wr  = unlocked && dat_wr && is_bank_idx(cur_index);
  assign ldn_wr   = unlocked && dat_wr && cur_index == LDN_IDX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked  <= 1'b0;
      cur_index <= 8'h00;
      ldn       <= 8'h00;
      ld_we     <= 1'b0;
      ld_wdata  <= 8'h00;
    end else begin
      if (unlock_evt)    unlocked <= 1'b1;
      else if (exit_evt) unlocked <= 1'b0;
      if (idx_wr && unlocked) cur_index <= wdata;
      if (ldn_wr) ldn <= wdata;
      ld_we <= bank_wr;
      if (bank_wr) ld_wdata <= wdata;
    end
  end
endmodule

// File: rtl/cfgp_rd_mux.sv
module cfgp_rd_mux
  import cfgp_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h8712,
  parameter logic [7:0]  CHIP_REV = 8'hA7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dat_rd,
  input  logic       unlocked,
  input  logic [7:0] cur_index,
  input  logic [7:0] ldn,
  input  logic [7:0] ld_rdata,
  output logic [7:0] io_rdata
);
  logic [7:0] rd_value;

  always_comb begin
    if (!unlocked)                  rd_value = IDLE_READ;
    else if (is_bank_idx(cur_index)) rd_value = ld_rdata;
    else                            rd_value = global_value(cur_index, ldn, CHIP_ID, CHIP_REV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      io_rdata <= IDLE_READ;
    else if (dat_rd) io_rdata <= rd_value;
  end
endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport
  import cfgp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h002E,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h002F,
  parameter int unsigned KEY_LEN  = 4,
  parameter logic [8*KEY_MAX_BYTES-1:0] KEY = 64'h0000_0000_8701_5555,
  parameter logic [15:0] CHIP_ID  = 16'h8712,
  parameter logic [7:0]  CHIP_REV = 8'hA7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [7:0]        ld_bank,
  output logic [7:0]        ld_index,
  output logic [7:0]        ld_wdata,
  output logic              ld_we,
  input  logic [7:0]        ld_rdata
);
  localparam logic [7:0] LAST_KEY = key_byte(KEY, KEY_LEN, KEY_LEN - 1);

  logic idx_wr;
  logic dat_wr;
  logic dat_rd;
  logic unlock_evt;
  logic exit_evt;
  logic unlocked;
  logic [7:0] cur_index;
  logic [7:0] ldn;

  assign idx_wr = io_wr && io_addr == IDX_ADDR;
  assign dat_wr = io_wr && io_addr == DAT_ADDR;
  assign dat_rd = io_rd && io_addr == DAT_ADDR;

  cfgp_key_match #(.KEY_LEN(KEY_LEN), .KEY(KEY)) u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_wr     (idx_wr && !unlocked),
    .key_data   (io_wdata),
    .unlock_evt (unlock_evt)
  );

  cfgp_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr     (idx_wr),
    .dat_wr     (dat_wr),
    .wdata      (io_wdata),
    .unlock_evt (unlock_evt),
    .unlocked   (unlocked),
    .exit_evt   (exit_evt),
    .cur_index  (cur_index),
    .ldn        (ldn),
    .ld_we      (ld_we),
    .ld_wdata   (ld_wdata)
  );

  cfgp_rd_mux #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .dat_rd    (dat_rd),
    .unlocked  (unlocked),
    .cur_index (cur_index),
    .ldn       (ldn),
    .ld_rdata  (ld_rdata),
    .io_rdata  (io_rdata)
  );

  assign ld_bank  = ldn;
  assign ld_index = cur_index;
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
  import cfgp_pkg::*;
#(
  parameter logic [7:0] LAST_KEY = 8'h55
) (
  input logic       clk,
  input logic       rst_n,
  input logic       idx_wr,
  input logic       dat_wr,
  input logic       dat_rd,
  input logic [7:0] io_wdata,
  input logic       unlocked,
  input logic [7:0] cur_index,
  input logic [7:0] ld_bank,
  input logic       ld_we,
  input logic [7:0] io_rdata
);
  assert_unlock_on_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(idx_wr && io_wdata == LAST_KEY));

  assert_locked_index_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(cur_index));

  assert_locked_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !unlocked) |=> !ld_we);

  assert_locked_read_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !unlocked) |=> io_rdata == IDLE_READ);

  assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_wr && unlocked && cur_index == LDN_IDX) |=> $stable(ld_bank));

  assert_bank_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && unlocked && cur_index >= BANK_BASE) |=> ld_we);

  assert_no_stray_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_wr && unlocked && cur_index >= BANK_BASE) |=> !ld_we);

  assert_exit_relock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && unlocked && cur_index == EXIT_IDX && io_wdata == EXIT_CMD) |=> !unlocked);

  assert_read_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_rd |=> $stable(io_rdata));
endmodule

bind cfg_keyport cfgp_checker #(.LAST_KEY(LAST_KEY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idx_wr    (idx_wr),
  .dat_wr    (dat_wr),
  .dat_rd    (dat_rd),
  .io_wdata  (io_wdata),
  .unlocked  (unlocked),
  .cur_index (cur_index),
  .ld_bank   (ld_bank),
  .ld_we     (ld_we),
  .io_rdata  (io_rdata)
);

// File: tb/cfg_keyport_tb.sv
module cfg_keyport_tb;
  localparam logic [15:0] P_IDX = 16'h002E;
  localparam logic [15:0] P_DAT = 16'h002F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [7:0]  ld_bank;
  logic [7:0]  ld_index;
  logic [7:0]  ld_wdata;
  logic        ld_we;
  logic [7:0]  ld_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_q = 1'b0;

  always #10 clk = ~clk;

  // Model of the banked register files: a fixed scramble of bank and index.
  assign ld_rdata = ld_bank ^ ld_index ^ 8'h3C;

  cfg_keyport u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .ld_bank(ld_bank), .ld_index(ld_index),
    .ld_wdata(ld_wdata), .ld_we(ld_we), .ld_rdata(ld_rdata)
  );

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: a read captured at the rising edge is compared at the next falling edge.
  always @(posedge clk) rd_q <= io_rd && io_addr == P_DAT;

  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: actual %02h expected none", io_rdata);
      end else begin
        check8(io_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] exp, input string tag);
    @(negedge clk);
    io_addr = P_DAT; io_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic send_key();
    io_write(P_IDX, 8'h87); io_write(P_IDX, 8'h01);
    io_write(P_IDX, 8'h55); io_write(P_IDX, 8'h55);
  endtask

  task automatic read_at(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    io_write(P_IDX, idx);
    io_read(exp, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check8(io_rdata, 8'hFF, "R1 rdata");
    check8({7'd0, ld_we}, 8'h00, "R1 ld_we");
    check8(ld_bank, 8'h00, "R1 ld_bank");
    check8(ld_index, 8'h00, "R1 ld_index");

    // R4 locked behaviour
    io_read(8'hFF, "R4 locked read");
    io_write(P_DAT, 8'h33);
    check8({7'd0, ld_we}, 8'h00, "R4 locked write no strobe");
    io_write(P_IDX, 8'h07);
    check8(ld_index, 8'h00, "R2 locked index unchanged");

    // R3 broken key
    io_write(P_IDX, 8'h87); io_write(P_IDX, 8'h01);
    io_write(P_IDX, 8'h55); io_write(P_IDX, 8'h12);
    io_write(P_IDX, 8'h55);
    io_read(8'hFF, "R3 broken key stays locked");

    // R3 restart on first key byte
    io_write(P_IDX, 8'h87); io_write(P_IDX, 8'h01);
    send_key();
    // R2 unlocked: identity reads
    read_at(8'h20, 8'h87, "R2 R6 id high after key");
    read_at(8'h21, 8'h12, "R6 id low");
    io_write(P_DAT, 8'h99);
    check8({7'd0, ld_we}, 8'h00, "R10 no strobe for id write");
    io_read(8'h12, "R6 id read-only");
    read_at(8'h22, 8'h07, "R7 revision low nibble");
    read_at(8'h25, 8'h00, "R10 unassigned reads zero");

    // R5 logical device number
    io_write(P_IDX, 8'h07);
    io_write(P_DAT, 8'h05);
    check8(ld_bank, 8'h05, "R5 bank output");
    io_read(8'h05, "R5 ldn readback");

    // R8 banked write and read
    io_write(P_IDX, 8'h41);
    io_write(P_DAT, 8'hC3);
    check8({7'd0, ld_we}, 8'h01, "R8 strobe");
    check8(ld_wdata, 8'hC3, "R8 wdata");
    check8(ld_index, 8'h41, "R8 index");
    check8(ld_bank, 8'h05, "R8 bank");
    @(negedge clk);
    check8({7'd0, ld_we}, 8'h00, "R8 single pulse");
    io_read(8'h05 ^ 8'h41 ^ 8'h3C, "R8 banked read");
    repeat (2) @(negedge clk);
    check8(io_rdata, 8'h05 ^ 8'h41 ^ 8'h3C, "R12 read data held");

    // R11 other addresses
    io_write(16'h012E, 8'h07);
    io_write(16'h002D, 8'h02);
    check8(ld_index, 8'h41, "R11 foreign index write");
    io_write(16'h0030, 8'h02);
    check8({7'd0, ld_we}, 8'h00, "R11 foreign data write");

    // R9 exit command
    io_write(P_IDX, 8'h02);
    io_write(P_DAT, 8'h01);
    io_read(8'h00, "R9 wrong exit value stays unlocked");
    io_write(P_DAT, 8'h02);
    io_read(8'hFF, "R9 relocked");
    io_write(P_DAT, 8'h09);
    check8({7'd0, ld_we}, 8'h00, "R4 relocked write dropped");
    check8(ld_bank, 8'h05, "R4 bank kept while locked");

    // R3 repeated first byte, then unlock
    io_write(P_IDX, 8'h87);
    send_key();
    read_at(8'h07, 8'h05, "R3 repeated first byte unlocks");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule